// File: doc/BRIEF.md
# Colour Palette Stream Loader and Index Lookup

This block fills a 256-entry colour lookup memory from a stream of 32-bit words and then uses that memory to turn pixel indices into 12-bit RGB 4:4:4 colours. A load starts with a one-cycle `loadStart` strobe. Every accepted word carries two 16-bit halfwords, and the low halfword is taken first. Only bits 11:0 of a halfword hold colour: red in 11:8, green in 7:4 and blue in 3:0. The very first halfword of a load is a header. Its top nibble (bits 15:12 of the first word) is a pixel-depth code, and its low 12 bits are colour entry 0.

The depth code sets how many words the load takes. It is also held on `depthCode`, where it chooses how the pixel path works. Codes 0, 1 and 2 select 1, 2 and 4 bits per pixel and a 256-byte table. Code 3 selects 8 bits per pixel and a 512-byte table. Code 4 and every higher code select the direct 12/16-bit mode, which has a 32-byte table. A load of a table of B bytes takes B/4 + 1 words. After the last word, `paletteLoaded` pulses once.

In direct mode the lookup is skipped and the pixel passes straight through. The block does not include the stream source or the pixel fetch logic.

Top module: `palStreamLut`

## Requirements
- R1: After reset `depthCode` is 3. The depth code is taken from bits 15:12 of the first word accepted after `loadStart` and is held until the next load's first word. It does not change while no load is in progress.
- R2: The length of a load depends on the header code: 65 words for codes 0–2, 129 words for code 3, and 9 words for code 4 and all higher codes. `paletteLoaded` is high for exactly one cycle, in the cycle after the last word is accepted. In that same cycle `loading` is already low, and the pulse never comes earlier.
- R3: Word w writes its bits 11:0 to entry 2w and its bits 27:16 to entry 2w+1. The upper nibble of each halfword is dropped, so entry 0 is the header's low 12 bits. Halfwords that would land above entry 255 are discarded.
- R4: When the depth code is 3, `pixOut` one cycle after `pixValid` equals `{4'b0, entry[pixIn[7:0]]}`. `pixOutValid` is `pixValid` delayed by one cycle. `pixIn[15:8]` is ignored.
- R5: For codes 0, 1 and 2 the index is `pixIn[0]`, `pixIn[1:0]` and `pixIn[3:0]` respectively, and the higher pixel bits are ignored.
- R6: For code 4 and above, `pixOut` one cycle after `pixValid` equals `pixIn` unchanged.
- R7: When no load is in progress, `wordValid` words change neither the table, `loading` nor `paletteLoaded`.
- R8: A `loadStart` during a load restarts it. The next word is treated as a new header and counting starts again from zero, with no pulse for the abandoned load. `loadStart` takes priority over a `wordValid` in the same cycle.
- R9: While `rstN` is low, `loading`, `paletteLoaded`, `pixOutValid` and `pixOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| loadStart | input | 1 | One-cycle strobe that begins (or restarts) a palette load |
| wordValid | input | 1 | `wordData` carries a palette word this cycle |
| wordData | input | 32 | Palette word, low halfword first |
| pixValid | input | 1 | `pixIn` carries a pixel this cycle |
| pixIn | input | 16 | Pixel index, or a direct pixel in direct mode |
| pixOut | output | 16 | Looked-up colour (zero-extended) or passed-through pixel |
| pixOutValid | output | 1 | `pixOut` is valid |
| depthCode | output | 4 | Latched pixel-depth code |
| loading | output | 1 | A load is in progress |
| paletteLoaded | output | 1 | One-cycle pulse when a load completes |

## Verification
The assertions assume that `loadStart` is a single-cycle strobe. They also assume that the stream source never sends more words than the header asks for without a new `loadStart`. The stimulus meets both assumptions: it pulses `loadStart` for one cycle, sends exactly the word count each depth code calls for, and abandons a load only by issuing a fresh `loadStart`. Pixel lookups are made only after a complete load, so every table entry read has been written. All inputs change half a cycle away from the capturing edge.

// File: rtl/palLoadPkg.sv
package palLoadPkg;
  localparam int IDX_W       = 8;
  localparam int NUM_ENTRIES = 1 << IDX_W;
  localparam int HALF_DEPTH  = NUM_ENTRIES / 2;
  localparam int DEPTH_W     = 4;
  localparam int CODE_LUT8   = 3;
  localparam int CODE_DIRECT = 4;
  localparam int BYTES_SMALL = NUM_ENTRIES;
  localparam int BYTES_LUT8  = 2 * NUM_ENTRIES;
  localparam int BYTES_DIR   = 32;
  localparam int MAX_WORDS   = BYTES_LUT8 / 4 + 1;
  localparam int CNT_W       = $clog2(MAX_WORDS + 1);

  typedef struct packed {
    logic               wrEn;
    logic [IDX_W-2:0]   wordIdx;
    logic [DEPTH_W-1:0] mode;
  } palStrobe_t;

  function automatic logic [CNT_W-1:0] wordsForCode(input logic [DEPTH_W-1:0] code);
    int bytes;
    if (code < DEPTH_W'(CODE_LUT8))      bytes = BYTES_SMALL;
    else if (code == DEPTH_W'(CODE_LUT8)) bytes = BYTES_LUT8;
    else                                  bytes = BYTES_DIR;
    return CNT_W'(bytes / 4 + 1);
  endfunction
endpackage

// File: rtl/palLoadCtrl.sv
module palLoadCtrl
  import palLoadPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadStart,
  input  logic               wordValid,
  input  logic [DEPTH_W-1:0] headerCode,
  output palStrobe_t         strobe,
  output logic               loading,
  output logic               paletteLoaded,
  output logic [DEPTH_W-1:0] depthCode
);
  logic [CNT_W-1:0]   wordCnt;
  logic [CNT_W-1:0]   cntNext;
  logic [DEPTH_W-1:0] depthQ;
  logic [DEPTH_W-1:0] curCode;
  logic               loadingQ;
  logic               loadedQ;
  logic               accept;
  logic               lastWord;

  // loadStart wins over a word in the same cycle
  assign accept   = loadingQ && wordValid && !loadStart;
  assign curCode  = (wordCnt == '0) ? headerCode : depthQ;
  assign cntNext  = wordCnt + 1'b1;
  assign lastWord = accept && (cntNext == wordsForCode(curCode));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadingQ <= 1'b0;
      loadedQ  <= 1'b0;
      wordCnt  <= '0;
      depthQ   <= DEPTH_W'(CODE_LUT8);
    end else begin
      loadedQ <= lastWord;
      if (loadStart) begin
        loadingQ <= 1'b1;
        wordCnt  <= '0;
      end else if (accept) begin
        if (wordCnt == '0) depthQ <= headerCode;
        if (lastWord) loadingQ <= 1'b0;
        wordCnt <= cntNext;
      end
    end
  end

  assign strobe.wrEn    = accept && (wordCnt < CNT_W'(HALF_DEPTH));
  assign strobe.wordIdx = wordCnt[IDX_W-2:0];
  assign strobe.mode    = depthQ;
  assign loading        = loadingQ;
  assign paletteLoaded  = loadedQ;
  assign depthCode      = depthQ;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    paletteLoaded |=> !paletteLoaded); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    paletteLoaded |-> !loading); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    loading |-> (wordCnt < CNT_W'(MAX_WORDS))); // R2
  AST_DEPTH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !loading |=> $stable(depthCode)); // R1
  AST_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    loadStart |=> (loading && !paletteLoaded)); // R8
endmodule

// File: rtl/palLoadData.sv
module palLoadData
  import palLoadPkg::*;
#(
  parameter int ENTRY_W = 12,
  parameter int PIX_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  palStrobe_t         strobe,
  input  logic [ENTRY_W-1:0] loData,
  input  logic [ENTRY_W-1:0] hiData,
  input  logic               pixValid,
  input  logic [PIX_W-1:0]   pixIn,
  output logic [PIX_W-1:0]   pixOut,
  output logic               pixOutValid
);
  localparam int NUM_BANKS = 2;

  logic [IDX_W-1:0]                  idx;
  logic [NUM_BANKS-1:0][ENTRY_W-1:0] rdData;
  logic [ENTRY_W-1:0]                colour;
  logic                              bypass;

  // index width follows the depth code
  always_comb begin
    case (strobe.mode)
      DEPTH_W'(0): idx = IDX_W'(pixIn[0]);
      DEPTH_W'(1): idx = IDX_W'(pixIn[1:0]);
      DEPTH_W'(2): idx = IDX_W'(pixIn[3:0]);
      default:     idx = pixIn[IDX_W-1:0];
    endcase
  end

  // even entries in bank 0 (low halfwords), odd entries in bank 1
  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic [ENTRY_W-1:0] mem [HALF_DEPTH];
    always_ff @(posedge clk) begin
      if (strobe.wrEn) mem[strobe.wordIdx] <= (b == 0) ? loData : hiData;
    end
    assign rdData[b] = mem[idx[IDX_W-1:1]];
  end

  assign colour = rdData[idx[0]];
  assign bypass = strobe.mode >= DEPTH_W'(CODE_DIRECT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOut      <= '0;
      pixOutValid <= 1'b0;
    end else begin
      pixOutValid <= pixValid;
      if (pixValid) pixOut <= bypass ? pixIn : PIX_W'(colour);
    end
  end

  AST_OUT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> pixOutValid); // R4
  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !pixOutValid); // R4
  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && strobe.mode >= DEPTH_W'(CODE_DIRECT)) |=> (pixOut == $past(pixIn))); // R6
  AST_LOOKUP_ZERO_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && strobe.mode < DEPTH_W'(CODE_DIRECT)) |=> (pixOut[PIX_W-1:ENTRY_W] == '0)); // R4
endmodule

// File: rtl/palStreamLut.sv
module palStreamLut
  import palLoadPkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int ENTRY_W = 12,
  parameter int PIX_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadStart,
  input  logic               wordValid,
  input  logic [WORD_W-1:0]  wordData,
  input  logic               pixValid,
  input  logic [PIX_W-1:0]   pixIn,
  output logic [PIX_W-1:0]   pixOut,
  output logic               pixOutValid,
  output logic [DEPTH_W-1:0] depthCode,
  output logic               loading,
  output logic               paletteLoaded
);
  localparam int HALF_W = WORD_W / 2;

  palStrobe_t strobe;
  logic       unusedHiNibble;

  assign unusedHiNibble = ^wordData[WORD_W-1 -: (HALF_W - ENTRY_W)];

  palLoadCtrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .loadStart    (loadStart),
    .wordValid    (wordValid),
    .headerCode   (wordData[HALF_W-1 -: DEPTH_W]),
    .strobe       (strobe),
    .loading      (loading),
    .paletteLoaded(paletteLoaded),
    .depthCode    (depthCode)
  );

  palLoadData #(.ENTRY_W(ENTRY_W), .PIX_W(PIX_W)) i_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .loData     (wordData[ENTRY_W-1:0]),
    .hiData     (wordData[HALF_W +: ENTRY_W]),
    .pixValid   (pixValid),
    .pixIn      (pixIn),
    .pixOut     (pixOut),
    .pixOutValid(pixOutValid)
  );
endmodule

// File: tb/test_palStreamLut.sv
`timescale 1ns/1ps
module test_palStreamLut;
  logic        clk = 1'b0;
  logic        rstN;
  logic        loadStart, wordValid, pixValid;
  logic [31:0] wordData;
  logic [15:0] pixIn;
  logic [15:0] pixOut;
  logic        pixOutValid, loading, paletteLoaded;
  logic [3:0]  depthCode;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [11:0] model [256];

  localparam int NVEC = 8;
  localparam logic [15:0] PIX_TAB [NVEC] = '{16'h0000, 16'h0001, 16'h00FF, 16'h1280,
                                            16'hFF7E, 16'h0011, 16'hABCD, 16'h00FE};

  always #2.5 clk = ~clk;

  palStreamLut i_palStreamLut (
    .clk(clk), .rstN(rstN), .loadStart(loadStart), .wordValid(wordValid),
    .wordData(wordData), .pixValid(pixValid), .pixIn(pixIn), .pixOut(pixOut),
    .pixOutValid(pixOutValid), .depthCode(depthCode), .loading(loading),
    .paletteLoaded(paletteLoaded)
  );

  function automatic logic [11:0] pal(input int i, input int seed);
    return 12'(i * 37 + seed * 291 + 5);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic startLoad();
    @(negedge clk);
    loadStart = 1'b1;
    @(negedge clk);
    loadStart = 1'b0;
    chk("R8 loading after start", 32'(loading), 32'd1);
  endtask

  // sends nWords words; if finalWord, expects the pulse after the last one
  task automatic sendWords(input logic [3:0] code, input int nWords, input int seed,
                           input bit finalWord, input string req);
    int early = 0;
    for (int w = 0; w < nWords; w++) begin
      logic [15:0] lo, hi;
      lo = (w == 0) ? {code, pal(0, seed)} : {4'hC, pal(2 * w, seed)};
      hi = {4'h5, pal(2 * w + 1, seed)};
      wordValid = 1'b1;
      wordData  = {hi, lo};
      if (2 * w < 256)     model[2 * w]     = pal(2 * w, seed);
      if (2 * w + 1 < 256) model[2 * w + 1] = pal(2 * w + 1, seed);
      @(negedge clk);
      if (w < nWords - 1 || !finalWord) begin
        if (paletteLoaded) early++;
      end else begin
        chk({req, " pulse after last word"}, 32'(paletteLoaded), 32'd1);
        chk({req, " loading low at pulse"}, 32'(loading), 32'd0);
      end
    end
    wordValid = 1'b0;
    chk({req, " no early pulse"}, 32'(early), 32'd0);
    @(negedge clk);
    chk({req, " pulse lasts one cycle"}, 32'(paletteLoaded), 32'd0);
  endtask

  task automatic lookup(input logic [15:0] pix, input logic [15:0] exp, input string req);
    pixValid = 1'b1;
    pixIn    = pix;
    @(negedge clk);
    pixValid = 1'b0;
    chk({req, " valid"}, 32'(pixOutValid), 32'd1);
    chk({req, " data"}, 32'(pixOut), 32'(exp));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; loadStart = 1'b0; wordValid = 1'b0; pixValid = 1'b1;
    wordData = '0; pixIn = 16'h1234;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 loading", 32'(loading), 32'd0);
    chk("R9 paletteLoaded", 32'(paletteLoaded), 32'd0);
    chk("R9 pixOutValid", 32'(pixOutValid), 32'd0);
    chk("R9 pixOut", 32'(pixOut), 32'd0);
    pixValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset depth", 32'(depthCode), 32'd3);

    // R2/R3: 8-bit load, 129 words, word 128 discarded
    startLoad();
    sendWords(4'd3, 129, 1, 1'b1, "R2 code3");
    chk("R1 depth 3", 32'(depthCode), 32'd3);
    lookup(16'h0000, {4'h0, pal(0, 1)}, "R3 entry0 from header");
    lookup(16'h0001, {4'h0, pal(1, 1)}, "R3 entry1 high half");
    lookup(16'h00FF, {4'h0, pal(255, 1)}, "R3 entry255");
    // R4 table walk
    for (int v = 0; v < NVEC; v++)
      lookup(PIX_TAB[v], {4'h0, model[PIX_TAB[v][7:0]]}, "R4 table");

    // R7 words while idle are ignored
    @(negedge clk);
    wordValid = 1'b1; wordData = 32'hFFFF_FFFF;
    @(negedge clk);
    wordValid = 1'b0;
    chk("R7 no load started", 32'(loading), 32'd0);
    chk("R7 no pulse", 32'(paletteLoaded), 32'd0);
    lookup(16'h0000, {4'h0, model[0]}, "R7 entry0 kept");
    lookup(16'h0001, {4'h0, model[1]}, "R7 entry1 kept");

    // R5 reduced depths
    startLoad();
    sendWords(4'd2, 65, 2, 1'b1, "R2 code2");
    chk("R1 depth 2", 32'(depthCode), 32'd2);
    lookup(16'hFFF3, {4'h0, model[3]}, "R5 4bpp index");
    startLoad();
    sendWords(4'd1, 65, 3, 1'b1, "R2 code1");
    lookup(16'h00FE, {4'h0, model[2]}, "R5 2bpp index");
    startLoad();
    sendWords(4'd0, 65, 4, 1'b1, "R2 code0");
    chk("R1 depth 0", 32'(depthCode), 32'd0);
    lookup(16'h00FF, {4'h0, model[1]}, "R5 1bpp index");

    // R6 direct mode
    startLoad();
    sendWords(4'd4, 9, 5, 1'b1, "R2 code4");
    chk("R1 depth 4", 32'(depthCode), 32'd4);
    lookup(16'hBEEF, 16'hBEEF, "R6 bypass");
    lookup(16'h0003, 16'h0003, "R6 bypass small");

    // R8 restart mid-load
    startLoad();
    sendWords(4'd3, 3, 6, 1'b0, "R8 partial");
    startLoad();
    sendWords(4'd4, 9, 7, 1'b1, "R8 restarted code4");
    chk("R8 depth after restart", 32'(depthCode), 32'd4);

    // R2 unknown high code behaves as direct length
    startLoad();
    sendWords(4'd9, 9, 8, 1'b1, "R2 code9");
    chk("R1 depth 9", 32'(depthCode), 32'd9);
    lookup(16'h5A5A, 16'h5A5A, "R6 bypass code9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule